// File: doc/BRIEF.md
# Offset-Corrected Integer Matrix Multiply Array

This block is a grid of dot-product tiles that multiplies a small A matrix (ROWS by DEPTH) by a small B matrix (DEPTH by COLS) and produces every element of the ROWS by COLS result in the same beat. Each operand element is an 8-bit signed integer. A scalar zero point is subtracted from each element before it is multiplied: one scalar for A and one for B. Each tile in row i sees row i of A. Each tile in column j sees column j of B.

Operands arrive on one valid/ready beat that carries the whole A and B matrices as flat buses. A per-beat flag selects one of two modes. In the first mode the new dot products are added to the results held in the 32-bit accumulators. In the second mode the new dot products replace those results. The accumulate mode lets software split a larger product along the inner dimension into several beats. The result bus is registered and carries a valid flag. When the consumer holds back, the pipeline stalls and the input side stops accepting beats.

Top module: `zpmm_array`

## Requirements
- R1: While out_valid is high, result element C[i][j] is the sum over k of (A[i][k] − za) × (B[k][j] − zb). A[i][k] sits at a_bus bits [(i*DEPTH+k)*8 +: 8], which is row-major. B[k][j] sits at b_bus bits [(j*DEPTH+k)*8 +: 8], which is column-major. C[i][j] sits at c_bus bits [(i*COLS+j)*32 +: 32], which is row-major and two's complement.
- R2: Operands and zero points are signed 8-bit values. The subtraction is done without wrap-around. For example, element −128 with zero point 127 contributes −255.
- R3: A beat accepted with acc_en = 1 adds its dot products to the values held from the previous result.
- R4: A beat accepted with acc_en = 0 discards the held values and yields only its own dot products.
- R5: A beat is accepted on a rising edge where in_valid and in_ready are both high. With out_ready held high, out_valid is low after that edge and high after the following edge.
- R6: While out_valid is high and out_ready is low, in_ready is low, and out_valid and c_bus keep their values.
- R7: Reset drives out_valid low, in_ready high and every result element to zero.
- R8: A result leaves on an edge where out_valid and out_ready are both high. If no beat is behind it, out_valid is low after that edge.
- R9: in_valid asserted while in_ready is low does not accept a beat. That beat neither produces a result nor contributes to a later accumulated result.
- R10: With out_ready held high, a beat is accepted on every cycle, and the results appear in the order the beats were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Array can take a beat this cycle |
| acc_en | input | 1 | 1: add to held result, 0: start fresh |
| za | input | 8 | Zero point subtracted from every A element |
| zb | input | 8 | Zero point subtracted from every B element |
| a_bus | input | ROWS*DEPTH*8 | A matrix, row-major |
| b_bus | input | COLS*DEPTH*8 | B matrix, column-major |
| out_valid | output | 1 | Result bus holds a valid result |
| out_ready | input | 1 | Consumer takes the result |
| c_bus | output | ROWS*COLS*32 | Result matrix, row-major |

## Verification
The bench builds the array with 2 rows, 3 columns and a depth of 3. The defaults are 2, 2 and 2. Because the rows and columns differ in number, a swapped row/column index or a wrong packing order for A, B or C lands on a different element and shows up as a mismatch. The odd depth exercises the sum over an uneven number of tiles. With this shape, extreme operands and zero points can drive every product to its largest magnitude. Stalls can also be held across several cycles while a refused beat waits on the input.

// File: rtl/zpmm_pkg.sv
package zpmm_pkg;
  localparam int DEF_ROWS  = 2;
  localparam int DEF_COLS  = 2;
  localparam int DEF_DEPTH = 2;
  localparam int DEF_IN_W  = 8;
  localparam int DEF_ACC_W = 32;

  // width of an operand after zero-point subtraction (one guard bit)
  function automatic int diff_width(input int in_w);
    return in_w + 1;
  endfunction

  // width of the product of two subtracted operands
  function automatic int prod_width(input int in_w);
    return 2 * (in_w + 1);
  endfunction
endpackage

// File: rtl/zpmm_flow_ctrl.sv
module zpmm_flow_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic acc_en,
  input  logic out_ready,
  output logic in_ready,
  output logic load_s1,
  output logic upd_acc,
  output logic acc_s1,
  output logic out_valid
);
  logic s1_vld_q, s1_vld_d;
  logic out_vld_q, out_vld_d;
  logic acc_s1_q, acc_s1_d;
  logic advance;

  always_comb begin
    advance   = !out_vld_q || out_ready;
    load_s1   = advance && in_valid;
    upd_acc   = advance && s1_vld_q;
    s1_vld_d  = advance ? in_valid : s1_vld_q;
    out_vld_d = advance ? s1_vld_q : out_vld_q;
    acc_s1_d  = load_s1 ? acc_en : acc_s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      out_vld_q <= 1'b0;
      acc_s1_q  <= 1'b0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      out_vld_q <= out_vld_d;
      acc_s1_q  <= acc_s1_d;
    end
  end

  assign in_ready  = advance;
  assign acc_s1    = acc_s1_q;
  assign out_valid = out_vld_q;
endmodule

// File: rtl/zpmm_tile_dot.sv
module zpmm_tile_dot #(
  parameter int DEPTH = zpmm_pkg::DEF_DEPTH,
  parameter int IN_W  = zpmm_pkg::DEF_IN_W,
  parameter int ACC_W = zpmm_pkg::DEF_ACC_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [DEPTH*IN_W-1:0]     row_vec,
  input  logic [DEPTH*IN_W-1:0]     col_vec,
  input  logic [IN_W-1:0]           za,
  input  logic [IN_W-1:0]           zb,
  output logic signed [ACC_W-1:0]   dot_q
);
  localparam int DW = zpmm_pkg::diff_width(IN_W);
  localparam int PW = zpmm_pkg::prod_width(IN_W);

  logic signed [DW-1:0]    da [DEPTH];
  logic signed [DW-1:0]    db [DEPTH];
  logic signed [PW-1:0]    pr [DEPTH];
  logic signed [DW-1:0]    za_x, zb_x;
  logic signed [ACC_W-1:0] dot_d;

  assign za_x = $signed({za[IN_W-1], za});
  assign zb_x = $signed({zb[IN_W-1], zb});

  for (genvar k = 0; k < DEPTH; k++) begin : g_lane
    assign da[k] = $signed({row_vec[k*IN_W+IN_W-1], row_vec[k*IN_W +: IN_W]}) - za_x;
    assign db[k] = $signed({col_vec[k*IN_W+IN_W-1], col_vec[k*IN_W +: IN_W]}) - zb_x;
    assign pr[k] = PW'(da[k]) * PW'(db[k]);
  end

  always_comb begin
    dot_d = '0;
    for (int k = 0; k < DEPTH; k++) begin
      dot_d = dot_d + ACC_W'(pr[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q <= '0;
    end else if (load) begin
      dot_q <= dot_d;
    end
  end
endmodule

// File: rtl/zpmm_acc_cell.sv
module zpmm_acc_cell #(
  parameter int ACC_W = zpmm_pkg::DEF_ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    keep,
  input  logic signed [ACC_W-1:0] dot,
  output logic signed [ACC_W-1:0] acc_q
);
  logic signed [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = keep ? (acc_q + dot) : dot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (upd) begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/zpmm_array.sv
module zpmm_array #(
  parameter int ROWS  = zpmm_pkg::DEF_ROWS,
  parameter int COLS  = zpmm_pkg::DEF_COLS,
  parameter int DEPTH = zpmm_pkg::DEF_DEPTH,
  parameter int IN_W  = zpmm_pkg::DEF_IN_W,
  parameter int ACC_W = zpmm_pkg::DEF_ACC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        acc_en,
  input  logic [IN_W-1:0]             za,
  input  logic [IN_W-1:0]             zb,
  input  logic [ROWS*DEPTH*IN_W-1:0]  a_bus,
  input  logic [COLS*DEPTH*IN_W-1:0]  b_bus,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [ROWS*COLS*ACC_W-1:0]  c_bus
);
  localparam int VEC_W = DEPTH * IN_W;

  logic load_s1, upd_acc, acc_s1;

  zpmm_flow_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .acc_en    (acc_en),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .load_s1   (load_s1),
    .upd_acc   (upd_acc),
    .acc_s1    (acc_s1),
    .out_valid (out_valid)
  );

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_col
      logic signed [ACC_W-1:0] dot;
      logic signed [ACC_W-1:0] acc;

      zpmm_tile_dot #(.DEPTH(DEPTH), .IN_W(IN_W), .ACC_W(ACC_W)) u_dot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_s1),
        .row_vec (a_bus[i*VEC_W +: VEC_W]),
        .col_vec (b_bus[j*VEC_W +: VEC_W]),
        .za      (za),
        .zb      (zb),
        .dot_q   (dot)
      );

      zpmm_acc_cell #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd_acc),
        .keep  (acc_s1),
        .dot   (dot),
        .acc_q (acc)
      );

      assign c_bus[(i*COLS+j)*ACC_W +: ACC_W] = acc;
    end
  end
endmodule

// File: rtl/zpmm_array_chk.sv
module zpmm_array_chk #(
  parameter int CW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] c_bus
);
  // R5: a result appears two edges after the beat that produced it
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  // R6: held result stays put while the consumer stalls
  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(c_bus)));

  // R6: input side refuses beats while the output is stalled
  assert_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: reset leaves the array idle and ready
  assert_reset_idle_R7: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));
endmodule

bind zpmm_array zpmm_array_chk #(.CW(ROWS*COLS*ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .c_bus     (c_bus)
);

// File: tb/tb_zpmm_array.sv
module tb_zpmm_array;
  localparam int R  = 2;
  localparam int C  = 3;
  localparam int D  = 3;
  localparam int IW = 8;
  localparam int AW = 32;

  logic clk;
  logic rst_n;
  logic in_valid, in_ready, acc_en, out_valid, out_ready;
  logic [IW-1:0] za, zb;
  logic [R*D*IW-1:0] a_bus;
  logic [C*D*IW-1:0] b_bus;
  logic [R*C*AW-1:0] c_bus;

  int am [R][D];
  int bm [D][C];
  int expc [R][C];
  int exp1 [R][C];
  int oa, ob;
  int checks, errors;

  zpmm_array #(.ROWS(R), .COLS(C), .DEPTH(D), .IN_W(IW), .ACC_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .acc_en(acc_en), .za(za), .zb(zb), .a_bus(a_bus), .b_bus(b_bus),
    .out_valid(out_valid), .out_ready(out_ready), .c_bus(c_bus)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic check_c(input string tag);
    bit bad = 0;
    int act = 0, ev = 0;
    checks++;
    for (int i = 0; i < R; i++)
      for (int j = 0; j < C; j++) begin
        int v = $signed(c_bus[(i*C+j)*AW +: AW]);
        if (!bad && v != expc[i][j]) begin
          bad = 1; act = v; ev = expc[i][j];
        end
      end
    if (bad) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, ev);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < R; i++)
      for (int k = 0; k < D; k++)
        am[i][k] = ((i*37 + k*13 + seed*59) % 256) - 128;
    for (int k = 0; k < D; k++)
      for (int j = 0; j < C; j++)
        bm[k][j] = ((k*71 + j*29 + seed*17 + 5) % 256) - 128;
  endtask

  task automatic drive_ops(input bit acc);
    for (int i = 0; i < R; i++)
      for (int k = 0; k < D; k++)
        a_bus[(i*D+k)*IW +: IW] = am[i][k][IW-1:0];
    for (int j = 0; j < C; j++)
      for (int k = 0; k < D; k++)
        b_bus[(j*D+k)*IW +: IW] = bm[k][j][IW-1:0];
    za = oa[IW-1:0];
    zb = ob[IW-1:0];
    acc_en = acc;
    in_valid = 1'b1;
  endtask

  task automatic calc(input bit acc);
    for (int i = 0; i < R; i++)
      for (int j = 0; j < C; j++) begin
        int s = 0;
        for (int k = 0; k < D; k++) s += (am[i][k] - oa) * (bm[k][j] - ob);
        expc[i][j] = acc ? expc[i][j] + s : s;
      end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 in_ready after reset", int'(in_ready), 1);
    chk(c_bus == '0, "R7 results zero after reset", int'(c_bus[AW-1:0]), 0);
  endtask

  // one beat, fresh start; checks timing, value and drain
  task automatic t_single(input int seed, input int za_v, input int zb_v, input string tag);
    out_ready = 1'b1;
    @(negedge clk);
    fill(seed); oa = za_v; ob = zb_v;
    drive_ops(1'b0); calc(1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R5 no result one edge after accept", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 result two edges after accept", int'(out_valid), 1);
    check_c(tag);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid falls after handshake", int'(out_valid), 0);
  endtask

  task automatic t_extreme();
    out_ready = 1'b1;
    @(negedge clk);
    for (int i = 0; i < R; i++) for (int k = 0; k < D; k++) am[i][k] = -128;
    for (int k = 0; k < D; k++) for (int j = 0; j < C; j++) bm[k][j] = 127;
    oa = 127; ob = -128;
    drive_ops(1'b0); calc(1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(expc[0][0] == -195075, "R2 model extreme value", expc[0][0], -195075);
    check_c("R2 nine-bit subtraction at extremes");
  endtask

  // back-to-back beats: fresh, accumulate, then fresh again
  task automatic t_accum();
    out_ready = 1'b1;
    @(negedge clk);
    fill(7); oa = 3; ob = -9;
    drive_ops(1'b0); calc(1'b0);
    exp1 = expc;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready for back-to-back beat", int'(in_ready), 1);
    fill(11); oa = -20; ob = 6;
    drive_ops(1'b1); calc(1'b1);
    @(negedge clk);
    fill(23); oa = 0; ob = 1;
    drive_ops(1'b0);
    begin
      int keep [R][C];
      keep = expc;
      expc = exp1;
      chk(out_valid == 1'b1, "R10 first result valid", int'(out_valid), 1);
      check_c("R10 first result in order");
      expc = keep;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_c("R3 accumulated second result");
    calc(1'b0);
    @(negedge clk);
    check_c("R4 fresh result discards held value");
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drained after burst", int'(out_valid), 0);
  endtask

  task automatic t_stall();
    out_ready = 1'b0;
    @(negedge clk);
    fill(31); oa = 12; ob = -4;
    drive_ops(1'b0); calc(1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 result present under stall", int'(out_valid), 1);
    // refused beat with junk operands
    a_bus = '1; b_bus = {(C*D){8'h55}}; za = 8'h80; zb = 8'h7f;
    acc_en = 1'b1; in_valid = 1'b1;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R6 in_ready low while stalled", int'(in_ready), 0);
      chk(out_valid == 1'b1, "R6 out_valid held", int'(out_valid), 1);
      check_c("R6 result held while stalled");
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 refused beat produced no result", int'(out_valid), 0);
    fill(43); oa = -1; ob = 2;
    drive_ops(1'b1); calc(1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 next result valid", int'(out_valid), 1);
    check_c("R9 refused beat not accumulated");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    in_valid = 1'b0; acc_en = 1'b0; out_ready = 1'b1;
    za = '0; zb = '0; a_bus = '0; b_bus = '0;
    oa = 0; ob = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single(1, 0, 0, "R1 product without zero points");
    t_single(2, 5, -3, "R1 product with zero points");
    t_single(5, -100, 90, "R1 product with large zero points");
    t_extreme();
    t_accum();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule